// File: doc/BRIEF.md
# Watchdog Timer with Power-of-Two Period Select

This block watches for a stalled program. A free-running tick input drives a counter. Software must restart that counter before it reaches a chosen limit. If the limit is reached, the block pulses a reset request for one clock cycle and then starts counting again from zero. Software restarts the count with a clear strobe. Any write to the control register also restarts the count.

The limit comes from a 4-bit period code in an 8-bit control register. Code n (0 to 11) sets a limit of 2^(n+5) ticks, so the range is 32 to 65536 ticks. Codes 12 to 15 are reserved and behave like the longest limit. A software enable bit in the same register turns the watchdog on or off. A hardware configuration input overrides that bit and keeps the watchdog running whatever the bit holds. While the watchdog is off, the counter is held at zero.

Top module: `wdt_top`

## Requirements
- R1: `rd_data` always shows the stored register. Bit 0 is the software enable, bits 4:1 are the period code exactly as written (reserved values included), and bits 7:5 always read zero.
- R2: After a synchronous active-low reset, `rd_data` is 8'h08 (code 4, enable 0) and `bite` is 0.
- R3: For code n from 0 to 11, with the watchdog running and no restart, `bite` goes high in the cycle after the clock edge that counts the 2^(n+5)-th tick since the last restart.
- R4: Codes 12 to 15 time out after 65536 ticks, the same as code 11.
- R5: When `force_on` is 1, the watchdog counts and times out even if the enable bit is 0.
- R6: When `force_on` is 0 and the enable bit is 0, `bite` stays low and the count is held at zero. After the watchdog is turned on again, a full period is needed before a timeout.
- R7: A `kick` pulse sets the count to zero. If a kick arrives on the same edge as the terminal tick, the kick wins and no timeout occurs.
- R8: A register write sets the count to zero. The period just written applies from that edge onward, and a write on the terminal tick suppresses the timeout.
- R9: `bite` lasts exactly one cycle. The count restarts at zero, so the next timeout needs another full period.
- R10: Only cycles with `tick` high advance the count. Cycles without a tick leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-enable tick, one per counted period |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| kick | input | 1 | Clear-watchdog strobe |
| force_on | input | 1 | Configuration enable, keeps the watchdog running |
| bite | output | 1 | One-cycle timeout reset request |

## Verification
Most faults in the hidden count show up only at `bite`. A wrong count or a wrong decoded limit moves the timeout pulse by at least one tick relative to the model. A missed restart shows as an early pulse within one period. A wrong held state shows up when the watchdog is turned on again. Because every cycle compares `bite` and `rd_data` against a tick-exact reference, a fault shows within the longest period in use (at most 65536 ticks after the last restart). Register faults show on the cycle after the write.

// File: rtl/wdt_pkg.sv
// Package wdt_pkg: shared constants for the watchdog timer.
// Assumes period codes map to powers of two starting at 2^WDT_MIN_LOG2.
package wdt_pkg;
    localparam int WDT_CTRL_W   = 8;   // control register width
    localparam int WDT_CODE_W   = 4;   // period code width
    localparam int WDT_MIN_LOG2 = 5;   // log2 of the shortest period
    localparam int WDT_MAX_CODE = 11;  // largest non-reserved code
    localparam int WDT_RST_CODE = 4;   // period code after reset
    localparam int WDT_CNT_W    = WDT_MIN_LOG2 + WDT_MAX_CODE + 1;
endpackage

// File: rtl/wdt_ctrl_reg.sv
// Module wdt_ctrl_reg: holds the period code and the software enable bit.
// Returns both on the read port, with the unused upper bits forced to zero.
// Assumes one write port. Write data is taken in full on the edge where wr_en is high.
module wdt_ctrl_reg #(
    parameter int CTRL_W   = 8,
    parameter int CODE_W   = 4,
    parameter int RST_CODE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CODE_W-1:0] code,
    output logic              sw_en,
    output logic [CTRL_W-1:0] rd_data
);
    localparam int PAD_W = CTRL_W - CODE_W - 1;

    logic [PAD_W-1:0] unused_pad;
    assign unused_pad = wr_data[CTRL_W-1:CODE_W+1];

    // Store the code and enable fields on a write; reset to the default period, off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code  <= CODE_W'(RST_CODE);
            sw_en <= 1'b0;
        end else if (wr_en) begin
            code  <= wr_data[CODE_W:1];
            sw_en <= wr_data[0];
        end
    end

    // Build the read value from the stored fields and zero padding.
    always_comb begin
        rd_data = {{PAD_W{1'b0}}, code, sw_en};
    end
endmodule

// File: rtl/wdt_period_dec.sv
// Module wdt_period_dec: turns a period code into the tick count that ends a period.
// Codes above MAX_CODE are clamped to MAX_CODE. Assumes CNT_W can hold 2^(MAX_CODE+MIN_LOG2).
module wdt_period_dec #(
    parameter int CODE_W   = 4,
    parameter int MIN_LOG2 = 5,
    parameter int MAX_CODE = 11,
    parameter int CNT_W    = 17
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  limit
);
    logic [CODE_W-1:0] eff_code;
    int                shamt;

    // Clamp reserved codes, then form the power-of-two limit.
    always_comb begin
        eff_code = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
        shamt    = int'(eff_code) + MIN_LOG2;
        limit    = CNT_W'(1) << shamt;
    end
endmodule

// File: rtl/wdt_counter.sv
// Module wdt_counter: tick counter that produces a one-cycle timeout pulse.
// Held at zero while not running or while restart is high; restart wins over a terminal tick.
// Assumes limit >= 2 and that limit stays constant between restarts.
module wdt_counter #(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             bite
);
    logic at_end;

    // Detect the tick that completes the period.
    always_comb begin
        at_end = (cnt == (limit - CNT_W'(1)));
    end

    // Advance on ticks, clear on restart or when idle, pulse at the end of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            bite <= 1'b0;
        end else begin
            bite <= 1'b0;
            if (!run || restart) begin
                cnt <= '0;
            end else if (tick) begin
                if (at_end) begin
                    cnt  <= '0;
                    bite <= 1'b1;
                end else begin
                    cnt <= cnt + CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/wdt_top.sv
// Module wdt_top: watchdog timer with a programmable power-of-two period.
// The watchdog runs when force_on is high or when the software enable bit is set.
// A kick or any register write restarts the count. Assumes all inputs are synchronous to clk.
module wdt_top
    import wdt_pkg::*;
#(
    parameter int CTRL_W   = WDT_CTRL_W,
    parameter int CODE_W   = WDT_CODE_W,
    parameter int MIN_LOG2 = WDT_MIN_LOG2,
    parameter int MAX_CODE = WDT_MAX_CODE,
    parameter int RST_CODE = WDT_RST_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] rd_data,
    input  logic              kick,
    input  logic              force_on,
    output logic              bite
);
    localparam int CNT_W = MIN_LOG2 + MAX_CODE + 1;

    logic [CODE_W-1:0] code_q;
    logic              sw_en_q;
    logic [CNT_W-1:0]  limit_w;
    logic [CNT_W-1:0]  cnt_q;
    logic              run_w;
    logic              restart_w;

    // Combine the enable sources and the restart sources.
    always_comb begin
        run_w     = force_on | sw_en_q;
        restart_w = kick | wr_en;
    end

    wdt_ctrl_reg #(
        .CTRL_W  (CTRL_W),
        .CODE_W  (CODE_W),
        .RST_CODE(RST_CODE)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .code   (code_q),
        .sw_en  (sw_en_q),
        .rd_data(rd_data)
    );

    wdt_period_dec #(
        .CODE_W  (CODE_W),
        .MIN_LOG2(MIN_LOG2),
        .MAX_CODE(MAX_CODE),
        .CNT_W   (CNT_W)
    ) u_dec (
        .code (code_q),
        .limit(limit_w)
    );

    wdt_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run    (run_w),
        .restart(restart_w),
        .limit  (limit_w),
        .cnt    (cnt_q),
        .bite   (bite)
    );
endmodule

// File: rtl/wdt_chk.sv
// Module wdt_chk: assertion checker for wdt_top, attached by bind.
// Checks the port-level rules and keeps the internal count inside the decoded limit.
module wdt_chk
    import wdt_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tick,
    input logic                 wr_en,
    input logic [WDT_CTRL_W-1:0] wr_data,
    input logic [WDT_CTRL_W-1:0] rd_data,
    input logic                 kick,
    input logic                 force_on,
    input logic                 bite,
    input logic [WDT_CNT_W-1:0] cnt,
    input logic [WDT_CNT_W-1:0] limit
);
    // R1: upper bits always read zero
    a_r1_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[WDT_CTRL_W-1:WDT_CODE_W+1] == '0);

    // R1: written fields read back on the next cycle
    a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == {3'b000, $past(wr_data[WDT_CODE_W:0])});

    // R3: the count never reaches the decoded limit
    a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < limit);

    // R6: no timeout while disabled
    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_on && !rd_data[0]) |=> !bite);

    // R7: a kick suppresses the timeout
    a_r7_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !bite);

    // R8: a write suppresses the timeout
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !bite);

    // R9: the pulse lasts exactly one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bite |=> !bite);

    // R10: no timeout without a tick
    a_r10_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !bite);
endmodule

bind wdt_top wdt_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .kick    (kick),
    .force_on(force_on),
    .bite    (bite),
    .cnt     (cnt_q),
    .limit   (limit_w)
);

// File: tb/sim_wdt_top.sv
`timescale 1ns/1ps
// Bench sim_wdt_top: directed and seeded random stimulus, compared each cycle
// against a tick-exact reference model built from the requirements.
module sim_wdt_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       kick = 1'b0;
    logic       force_on = 1'b0;
    logic       bite;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    logic [7:0] m_reg = 8'h08;
    int   m_cnt = 0;
    logic m_bite = 1'b0;

    always #2.5 clk = ~clk;

    wdt_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .kick(kick), .force_on(force_on), .bite(bite)
    );

    // Timeout length in ticks for a period code, reserved codes clamped (R3, R4).
    function automatic int ratio_of(input logic [3:0] c);
        int e;
        e = (c > 4'd11) ? 11 : int'(c);
        return 1 << (e + 5);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // One cycle: drive at negedge, advance the model at the edge, compare at the next negedge.
    task automatic step(input bit t, input bit k, input bit w, input logic [7:0] d,
                        input bit f, input string req);
        bit en;
        tick = t; kick = k; wr_en = w; wr_data = d; force_on = f;
        @(posedge clk);
        cyc++;
        en = f | m_reg[0];
        m_bite = 1'b0;
        if (w) begin
            m_reg = d & 8'h1F;
            m_cnt = 0;
        end else if (k || !en) begin
            m_cnt = 0;
        end else if (t) begin
            if (m_cnt + 1 == ratio_of(m_reg[4:1])) begin
                m_cnt = 0;
                m_bite = 1'b1;
            end else begin
                m_cnt++;
            end
        end
        @(negedge clk);
        check(bite == m_bite, req, int'(bite), int'(m_bite));
        check(rd_data == m_reg, req, int'(rd_data), int'(m_reg));
    endtask

    task automatic run_ticks(input int n, input bit f, input string req);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 8'h00, f, req);
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R2: reset values
        check(rd_data == 8'h08, "R2", int'(rd_data), 8'h08);
        check(bite == 1'b0, "R2", int'(bite), 0);
        rst_n = 1'b1;
        // R6: disabled, long run of ticks, no timeout
        run_ticks(600, 1'b0, "R6");
        // R5: forced on with enable bit 0, default code 4 = 512 ticks; R9 second period
        run_ticks(512, 1'b1, "R5");
        run_ticks(520, 1'b1, "R9");
        // R6: switch off midway, then back on: a full period is needed
        run_ticks(100, 1'b0, "R6");
        run_ticks(520, 1'b1, "R6");
        // R1: readback with pad bits written as ones, and a reserved code
        step(1'b0, 1'b0, 1'b1, 8'hFF, 1'b0, "R1");
        step(1'b0, 1'b0, 1'b1, 8'hE6, 1'b0, "R1");
        // R3: code 0 via software enable = 32 ticks, twice
        step(1'b0, 1'b0, 1'b1, 8'h01, 1'b0, "R3");
        run_ticks(70, 1'b0, "R3");
        // R10: sparse ticks, code 1 = 64 ticks
        step(1'b0, 1'b0, 1'b1, 8'h03, 1'b0, "R10");
        for (int i = 0; i < 400; i++) step(i % 3 == 0, 1'b0, 1'b0, 8'h00, 1'b0, "R10");
        // R7: kick mid count, then a kick on the terminal tick
        step(1'b0, 1'b0, 1'b1, 8'h01, 1'b0, "R7");
        run_ticks(20, 1'b0, "R7");
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R7");
        run_ticks(31, 1'b0, "R7");
        step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0, "R7");
        run_ticks(40, 1'b0, "R7");
        // R8: write on the terminal tick, and a new period taking effect
        step(1'b0, 1'b0, 1'b1, 8'h01, 1'b0, "R8");
        run_ticks(31, 1'b0, "R8");
        step(1'b1, 1'b0, 1'b1, 8'h05, 1'b0, "R8");
        run_ticks(140, 1'b0, "R8");
        // Seeded random mix (R3, R7, R8, R10) with short codes
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] d;
            d = {3'($urandom), 2'b00, 2'($urandom % 3), 1'($urandom)};
            step(1'($urandom % 2), ($urandom % 97) == 0, ($urandom % 211) == 0, d,
                 ($urandom % 5) == 0, "R3");
        end
        // R3: longest code 11 = 65536 ticks
        step(1'b0, 1'b0, 1'b1, 8'h17, 1'b0, "R3");
        run_ticks(65540, 1'b0, "R3");
        // R4: reserved code 12 behaves as 65536 ticks
        step(1'b0, 1'b0, 1'b1, 8'h19, 1'b0, "R4");
        run_ticks(65540, 1'b0, "R4");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule